// File: doc/BRIEF.md
# Program Fetch Unit with Empty-Stack Trap

This block supplies the instruction stream of a small 8-bit controller. A 15-bit program counter, kept as a 7-bit upper part and an 8-bit lower part, addresses a byte-wide program store. Each instruction byte leaves the block on a valid/ready stream together with the address it came from. The counter starts at zero after reset. An interrupt request steers it to the shared interrupt vector. A return loads it with an address popped from the stack.

A return taken while the stack pointer still holds its empty value sends the counter to the very top of the address space, 0x7FFF. No memory exists there, and a fetch at that address reads 0x00. That value decodes as the software-trap opcode, so an unbalanced return ends in a trap rather than in random code. Fetches from unimplemented addresses read 0x00, which is also the value of an erased location.

A host port with its own valid/ready request and response streams reads and writes the store. The last implemented byte is a configuration byte. When its security bit is set, the host port refuses every access. A refused read returns 0x00, a refused write changes nothing, and both raise an error pulse. Instruction fetches are never blocked by this bit.

Top module: `pfetch_unit`

Back-pressure rules:
- **Fetch stream.** A beat moves when `f_valid` and `f_ready` are both high. While `f_ready` is low and no redirect arrives, `f_addr` holds its value. An interrupt or return replaces the offered beat in the next cycle, whatever the state of `f_ready`.
- **Host port.** `h_req_ready` equals `!h_rsp_valid || h_rsp_ready`, so at most one read response is outstanding. A pending response holds its data until it is taken.

## Requirements
- R1: While reset is high and in the first cycle after it, the program counter is 0x0000. `f_valid` is low during reset and high from the first cycle after it. The whole store reads 0x00 after reset.
- R2: `f_data` is the stored byte at `f_addr`. An accepted beat advances the counter by one, with a carry out of the lower 8 bits into the upper 7 bits. A stalled beat (`f_ready` low) leaves `f_addr` unchanged.
- R3: An `irq_req` pulse makes `f_addr` equal 0x00FF in the next cycle. An interrupt takes priority over a return in the same cycle.
- R4: A `ret_req` pulse with `ret_sp` other than 0x6F loads `ret_pc` into the counter for the next cycle.
- R5: A `ret_req` pulse with `ret_sp` equal to 0x6F loads 0x7FFF into the counter for the next cycle.
- R6: At `f_addr` 0x7FFF, `f_data` is 0x00 and `trap_fetch` is high. `trap_fetch` is low at every other address. Accepting the beat at 0x7FFF wraps the counter to 0x0000.
- R7: A fetch at an address at or above MEM_BYTES, other than 0x7FFF, returns 0x00.
- R8: When security is off, a host write (`h_req_write`=1) stores `h_req_wdata`, and a host read returns the stored byte on `h_rsp_data` in the cycle after acceptance. Writes to addresses at or above MEM_BYTES are dropped, and reads there return 0x00.
- R9: A response waiting with `h_rsp_ready` low keeps `h_rsp_valid` high and `h_rsp_data` stable, and holds `h_req_ready` low.
- R10: Security is bit 5 of the byte at address MEM_BYTES-1. While that bit is set, a host read returns 0x00 and a host write leaves the store unchanged. In both cases `h_err` is high for exactly the one cycle after acceptance. Instruction fetches still return the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| f_valid | output | 1 | Fetch beat valid |
| f_ready | input | 1 | Fetch beat taken by consumer |
| f_addr | output | 15 | Address of the offered instruction byte (program counter) |
| f_data | output | 8 | Offered instruction byte |
| trap_fetch | output | 1 | Offered beat comes from the trap address 0x7FFF |
| irq_req | input | 1 | Interrupt redirect pulse |
| ret_req | input | 1 | Return redirect pulse |
| ret_sp | input | 8 | Stack pointer value at the return |
| ret_pc | input | 15 | Address popped from the stack |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request accepted this cycle if valid |
| h_req_write | input | 1 | 1 for write, 0 for read |
| h_req_addr | input | 15 | Host byte address |
| h_req_wdata | input | 8 | Host write byte |
| h_rsp_valid | output | 1 | Read response valid |
| h_rsp_ready | input | 1 | Read response taken |
| h_rsp_data | output | 8 | Read response byte |
| h_err | output | 1 | One-cycle pulse for a refused host access |

## Verification
The bench builds the unit with MEM_BYTES=256. At that size every location can be written and read back through the host port, and a single sequential fetch sweep goes through the whole store, past the carry from the lower byte at 0x00FF, and on into the unimplemented range up to 0x02FF. The small store also puts the configuration byte at 0x00FF, so the security bit can be switched with one host write. Redirects are then directed at the interrupt vector, at a normal return, at an empty-stack return, and at a simultaneous interrupt and return, followed by the trap fetch and its wrap back to zero.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int PC_HI_W = 7;
  localparam int PC_LO_W = 8;
  localparam int PC_W    = PC_HI_W + PC_LO_W;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic [PC_HI_W-1:0] hi;
    logic [PC_LO_W-1:0] lo;
  } pc_t;

  localparam logic [PC_W-1:0]   IRQ_VEC   = 15'h00FF;
  localparam logic [PC_W-1:0]   TRAP_ADDR = {PC_W{1'b1}};
  localparam logic [BYTE_W-1:0] TRAP_OP   = 8'h00;
  localparam logic [BYTE_W-1:0] BLANK     = 8'h00;

  typedef enum logic [1:0] {
    NX_SEQ   = 2'd0,
    NX_IRQ   = 2'd1,
    NX_RET   = 2'd2,
    NX_TRAP  = 2'd3
  } next_src_e;
endpackage

// File: rtl/pf_pc_ctrl.sv
module pf_pc_ctrl
  import pf_pkg::*;
#(
  parameter logic [7:0] EMPTY_SP = 8'h6F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic            irq_req,
  input  logic            ret_req,
  input  logic [7:0]      ret_sp,
  input  logic [PC_W-1:0] ret_pc,
  output pc_t             pc,
  output logic            running
);
  next_src_e src;
  pc_t       pc_inc;
  pc_t       pc_nxt;
  logic      lo_carry;

  always_comb begin
    if (irq_req)                          src = NX_IRQ;
    else if (ret_req && ret_sp == EMPTY_SP) src = NX_TRAP;
    else if (ret_req)                     src = NX_RET;
    else                                  src = NX_SEQ;
  end

  // split increment: lower byte first, carry ripples into the upper part
  always_comb begin
    {lo_carry, pc_inc.lo} = {1'b0, pc.lo} + {{PC_LO_W{1'b0}}, 1'b1};
    pc_inc.hi = pc.hi + {{(PC_HI_W-1){1'b0}}, lo_carry};
  end

  always_comb begin
    unique case (src)
      NX_IRQ:  pc_nxt = pc_t'(IRQ_VEC);
      NX_TRAP: pc_nxt = pc_t'(TRAP_ADDR);
      NX_RET:  pc_nxt = pc_t'(ret_pc);
      default: pc_nxt = advance ? pc_inc : pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      running <= 1'b0;
    end else begin
      running <= 1'b1;
      if (running) pc <= pc_nxt;
    end
  end
endmodule

// File: rtl/pf_store.sv
module pf_store
  import pf_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int SEC_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   f_addr,
  output logic [BYTE_W-1:0] f_byte,
  output logic              f_trap,
  input  logic [PC_W-1:0]   h_addr,
  output logic [BYTE_W-1:0] h_byte,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              secure
);
  localparam int AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
  localparam logic [AW-1:0] CFG_IDX = AW'(MEM_BYTES - 1);

  logic [BYTE_W-1:0] mem [MEM_BYTES];

  function automatic logic in_range(input logic [PC_W-1:0] a);
    return int'(a) < MEM_BYTES;
  endfunction

  function automatic logic [BYTE_W-1:0] look(input logic [PC_W-1:0] a);
    if (a == TRAP_ADDR)  return TRAP_OP;
    if (!in_range(a))    return BLANK;
    return mem[a[AW-1:0]];
  endfunction

  always_comb begin
    f_byte = look(f_addr);
    f_trap = (f_addr == TRAP_ADDR);
    h_byte = look(h_addr);
    secure = mem[CFG_IDX][SEC_BIT];
  end

  // store comes up erased; programming timing is outside this block
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= BLANK;
    end else if (wr_en && in_range(wr_addr) && wr_addr != TRAP_ADDR) begin
      mem[wr_addr[AW-1:0]] <= wr_data;
    end
  end
endmodule

// File: rtl/pf_host_port.sv
module pf_host_port
  import pf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              secure,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PC_W-1:0]   req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_en,
  output logic [PC_W-1:0]   wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              err
);
  logic take;

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    take      = req_valid && req_ready;
    wr_en     = take && req_write && !secure;
    wr_addr   = req_addr;
    wr_data   = req_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= BLANK;
      err       <= 1'b0;
    end else begin
      err <= take && secure;
      if (take && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= secure ? BLANK : rd_byte;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfetch_unit.sv
module pfetch_unit
  import pf_pkg::*;
#(
  parameter int         MEM_BYTES = 1024,
  parameter int         SEC_BIT   = 5,
  parameter logic [7:0] EMPTY_SP  = 8'h6F
) (
  input  logic        clk,
  input  logic        rst,
  output logic        f_valid,
  input  logic        f_ready,
  output logic [14:0] f_addr,
  output logic [7:0]  f_data,
  output logic        trap_fetch,
  input  logic        irq_req,
  input  logic        ret_req,
  input  logic [7:0]  ret_sp,
  input  logic [14:0] ret_pc,
  input  logic        h_req_valid,
  output logic        h_req_ready,
  input  logic        h_req_write,
  input  logic [14:0] h_req_addr,
  input  logic [7:0]  h_req_wdata,
  output logic        h_rsp_valid,
  input  logic        h_rsp_ready,
  output logic [7:0]  h_rsp_data,
  output logic        h_err
);
  pc_t               pc;
  logic              running;
  logic              secure;
  logic [BYTE_W-1:0] h_byte;
  logic              wr_en;
  logic [PC_W-1:0]   wr_addr;
  logic [BYTE_W-1:0] wr_data;

  assign f_valid = running;
  assign f_addr  = pc;

  pf_pc_ctrl #(.EMPTY_SP(EMPTY_SP)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .advance (f_valid && f_ready),
    .irq_req (irq_req),
    .ret_req (ret_req),
    .ret_sp  (ret_sp),
    .ret_pc  (ret_pc),
    .pc      (pc),
    .running (running)
  );

  pf_store #(.MEM_BYTES(MEM_BYTES), .SEC_BIT(SEC_BIT)) u_store (
    .clk     (clk),
    .rst     (rst),
    .f_addr  (pc),
    .f_byte  (f_data),
    .f_trap  (trap_fetch),
    .h_addr  (h_req_addr),
    .h_byte  (h_byte),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .secure  (secure)
  );

  pf_host_port u_host (
    .clk       (clk),
    .rst       (rst),
    .secure    (secure),
    .req_valid (h_req_valid),
    .req_ready (h_req_ready),
    .req_write (h_req_write),
    .req_addr  (h_req_addr),
    .req_wdata (h_req_wdata),
    .rd_byte   (h_byte),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rsp_valid (h_rsp_valid),
    .rsp_ready (h_rsp_ready),
    .rsp_data  (h_rsp_data),
    .err       (h_err)
  );
endmodule

// File: rtl/pfetch_unit_chk.sv
module pfetch_unit_chk #(
  parameter logic [7:0] EMPTY_SP = 8'h6F
) (
  input logic        clk,
  input logic        rst,
  input logic        f_valid,
  input logic        f_ready,
  input logic [14:0] f_addr,
  input logic [7:0]  f_data,
  input logic        trap_fetch,
  input logic        irq_req,
  input logic        ret_req,
  input logic [7:0]  ret_sp,
  input logic [14:0] ret_pc,
  input logic        h_req_valid,
  input logic        h_req_ready,
  input logic        h_req_write,
  input logic        h_rsp_valid,
  input logic        h_rsp_ready,
  input logic [7:0]  h_rsp_data,
  input logic        h_err
);
  AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (f_addr == 15'h0000)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (f_valid && !f_ready && !irq_req && !ret_req) |=> $stable(f_addr)); // R2
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (f_valid && irq_req) |=> (f_addr == 15'h00FF)); // R3
  AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
    (f_valid && ret_req && !irq_req && ret_sp != EMPTY_SP) |=> (f_addr == $past(ret_pc))); // R4
  AST_EMPTY_RET: assert property (@(posedge clk) disable iff (rst)
    (f_valid && ret_req && !irq_req && ret_sp == EMPTY_SP) |=> (f_addr == 15'h7FFF)); // R5
  AST_TRAP_BYTE: assert property (@(posedge clk) disable iff (rst)
    (f_addr == 15'h7FFF) |-> (trap_fetch && f_data == 8'h00)); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (h_rsp_valid && !h_rsp_ready) |=> (h_rsp_valid && $stable(h_rsp_data))); // R9
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (h_err && h_rsp_valid) |-> (h_rsp_data == 8'h00)); // R10
endmodule

bind pfetch_unit pfetch_unit_chk #(.EMPTY_SP(EMPTY_SP)) u_chk (.*);

// File: tb/pfetch_unit_test.sv
`timescale 1ns/1ps
module pfetch_unit_test;
  localparam int MB = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        f_valid, f_ready = 1'b0;
  logic [14:0] f_addr;
  logic [7:0]  f_data;
  logic        trap_fetch;
  logic        irq_req = 1'b0, ret_req = 1'b0;
  logic [7:0]  ret_sp = 8'h00;
  logic [14:0] ret_pc = '0;
  logic        h_req_valid = 1'b0, h_req_ready, h_req_write = 1'b0;
  logic [14:0] h_req_addr = '0;
  logic [7:0]  h_req_wdata = '0;
  logic        h_rsp_valid, h_rsp_ready = 1'b1;
  logic [7:0]  h_rsp_data;
  logic        h_err;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pfetch_unit #(.MEM_BYTES(MB)) uut (.*);

  function automatic logic [7:0] pat(input int a);
    if (a >= MB - 1) return 8'h00;
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic hwrite(input int a, input logic [7:0] d);
    h_req_valid = 1'b1; h_req_write = 1'b1;
    h_req_addr = 15'(a); h_req_wdata = d;
    step();
    h_req_valid = 1'b0; h_req_write = 1'b0;
  endtask

  task automatic hread(input int a);
    h_req_valid = 1'b1; h_req_write = 1'b0; h_req_addr = 15'(a);
    step();
    h_req_valid = 1'b0;
  endtask

  task automatic do_ret(input logic [7:0] sp, input logic [14:0] pc);
    ret_req = 1'b1; ret_sp = sp; ret_pc = pc;
    step();
    ret_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 valid low in reset", 32'(f_valid), 0);
    chk("R1 pc zero in reset", 32'(f_addr), 0);
    rst = 1'b0;
    step();
    chk("R1 valid after reset", 32'(f_valid), 1);
    chk("R1 start address", 32'(f_addr), 0);
    chk("R1 erased byte", 32'(f_data), 0);
    hread(17);
    chk("R1 erased host read", 32'(h_rsp_data), 0);
    step();

    // program every location, then read all back
    for (int a = 0; a < MB; a++) hwrite(a, pat(a));
    hwrite(MB + 16, 8'h5A);  // beyond the store: dropped
    for (int a = 0; a < MB; a++) begin
      hread(a);
      chk("R8 host readback", 32'(h_rsp_data), 32'(pat(a)));
    end
    hread(MB + 16);
    chk("R8 read beyond store", 32'(h_rsp_data), 0);
    chk("R8 no error when open", 32'(h_err), 0);
    step();

    // sequential sweep from 0 through the carry and into blank space
    do_ret(8'h40, 15'h0000);
    f_ready = 1'b1;
    for (int a = 0; a < 3 * MB; a++) begin
      chk("R2 sweep address", 32'(f_addr), a);
      if (a < MB) chk("R2 sweep byte", 32'(f_data), 32'(pat(a)));
      else        chk("R7 blank byte", 32'(f_data), 0);
      chk("R6 no trap flag", 32'(trap_fetch), 0);
      step();
    end
    f_ready = 1'b0;

    // stall
    begin
      logic [14:0] held;
      held = f_addr;
      step(); step();
      chk("R2 stall holds", 32'(f_addr), 32'(held));
    end

    // redirects
    irq_req = 1'b1; step(); irq_req = 1'b0;
    chk("R3 irq vector", 32'(f_addr), 32'h00FF);
    do_ret(8'h55, 15'h0023);
    chk("R4 return target", 32'(f_addr), 32'h0023);
    chk("R4 return byte", 32'(f_data), 32'(pat(35)));
    irq_req = 1'b1; ret_req = 1'b1; ret_sp = 8'h6F; ret_pc = 15'h0010;
    step();
    irq_req = 1'b0; ret_req = 1'b0;
    chk("R3 irq over return", 32'(f_addr), 32'h00FF);
    do_ret(8'h6F, 15'h0010);
    chk("R5 empty return", 32'(f_addr), 32'h7FFF);
    chk("R6 trap byte", 32'(f_data), 0);
    chk("R6 trap flag", 32'(trap_fetch), 1);
    f_ready = 1'b1; step(); f_ready = 1'b0;
    chk("R6 wrap to zero", 32'(f_addr), 0);
    do_ret(8'h6E, 15'h4000);
    chk("R7 high blank byte", 32'(f_data), 0);
    chk("R4 near-empty sp", 32'(f_addr), 32'h4000);

    // response back-pressure
    h_rsp_ready = 1'b0;
    hread(9);
    step();
    chk("R9 rsp held valid", 32'(h_rsp_valid), 1);
    chk("R9 rsp held data", 32'(h_rsp_data), 32'(pat(9)));
    chk("R9 req blocked", 32'(h_req_ready), 0);
    h_rsp_ready = 1'b1;
    step();
    chk("R9 rsp drained", 32'(h_rsp_valid), 0);

    // security on
    hwrite(MB - 1, 8'h20);
    chk("R10 config write open", 32'(h_err), 0);
    hread(5);
    chk("R10 refused read data", 32'(h_rsp_data), 0);
    chk("R10 refused read err", 32'(h_err), 1);
    step();
    chk("R10 err one cycle", 32'(h_err), 0);
    hwrite(5, 8'hC3);
    chk("R10 refused write err", 32'(h_err), 1);
    do_ret(8'h01, 15'h0005);
    chk("R10 store unchanged", 32'(f_data), 32'(pat(5)));
    do_ret(8'h01, 15'(MB - 1));
    chk("R10 fetch sees config", 32'(f_data), 32'h20);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule